// File: doc/BRIEF.md
# Processor exception entry unit

This unit carries out the architectural state changes that a small 32-bit RISC core makes when it takes an exception. The core presents a request with a numeric cause. With it come the current program counter, the next program counter, the branch target pending for a delay slot, a flag that marks the faulting instruction as sitting in a delay slot, and the current status word. On the clock edge where the request is accepted, the unit registers four values:

- the saved exception PC;
- the saved copy of the old status word;
- the new status word;
- the vector address that fetch should go to next.

The saved PC depends on two things. The first is whether the instruction was in a delay slot. The second is whether the cause belongs to the class that resumes after the instruction: tick timer, external interrupt, system call and floating point.

Each accepted request also produces one-cycle pulses for a TLB flush and for completion. It switches both instruction and data address translation to the untranslated mapping. A cause outside the valid range raises an abort pulse and does not vector. The unit is busy for exactly one cycle after an accept, and it ignores a request presented in that cycle.

Top module: `exc_entry_unit`

## Requirements
- R1: A request (`req_valid` high) in an idle cycle is accepted on that clock edge. `done_o` is high for exactly the following cycle. A request presented while `done_o` is high is ignored and leaves every output unchanged.
- R2: Outside a delay slot, for causes 5 (tick), 8 (external interrupt), 12 (system call) and 13 (floating point), `epcr_o` takes `next_pc`.
- R3: Outside a delay slot, for every other cause, `epcr_o` takes `cur_pc`.
- R4: Inside a delay slot (`in_dslot` high), for causes 5, 8, 12 and 13, `epcr_o` takes `branch_pc`.
- R5: Inside a delay slot, for every other cause, `epcr_o` takes `cur_pc - 4`.
- R6: `esr_o` takes the unmodified `cur_sr` on every accept.
- R7: `sr_o` takes `cur_sr` with these changes: bit 0 (supervisor) set; bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable) and 6 (instruction MMU enable) cleared; bit 13 (delay-slot exception) set when `in_dslot` is high and passed through otherwise. All other bits pass through.
- R8: For a valid cause (1 to 14 with the default count of 15), `pc_o` takes the cause shifted left by 8.
- R9: For a cause of 0 or of 15 and above, `abort_o` is high for the cycle after the accept and `pc_o` keeps its value. The other updates of R2 to R7 and R10 still happen.
- R10: `tlb_flush_o` is high for exactly the one cycle after each accept and low otherwise. `immu_bypass_o` and `dmmu_bypass_o` become 1 on the first accept.
- R11: After reset all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request |
| req_cause | input | 5 | Exception cause number |
| cur_pc | input | 32 | PC of the excepting instruction |
| next_pc | input | 32 | PC of the following instruction |
| branch_pc | input | 32 | Pending branch target for a delay slot |
| in_dslot | input | 1 | Excepting instruction is in a delay slot |
| cur_sr | input | 32 | Current status word |
| epcr_o | output | 32 | Saved exception PC |
| esr_o | output | 32 | Saved status word |
| sr_o | output | 32 | Status word after entry |
| pc_o | output | 32 | Vector address to fetch |
| done_o | output | 1 | Entry completed (one-cycle pulse) |
| tlb_flush_o | output | 1 | TLB flush request (one-cycle pulse) |
| abort_o | output | 1 | Cause out of range (one-cycle pulse) |
| immu_bypass_o | output | 1 | Instruction fetch uses untranslated addresses |
| dmmu_bypass_o | output | 1 | Data accesses use untranslated addresses |

## Verification
The hardest situation to bring about is a request held high across the busy cycle, where a second, different request must leave no trace. A directed case changes every input in that cycle and then checks that all outputs still hold the first entry. The four saved-PC choices and the abort path meet only at certain combinations of cause and delay-slot flag. Directed cases cover each of the four choices, both edges of the valid cause range, and cause 31. Seeded random requests then cover the full 5-bit cause space and random status words.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // Status word bit positions
  localparam int SRB_SUPV  = 0;
  localparam int SRB_TICKE = 1;
  localparam int SRB_INTE  = 2;
  localparam int SRB_DMMUE = 5;
  localparam int SRB_IMMUE = 6;
  localparam int SRB_DSEXC = 13;

  // Causes that resume after the faulting instruction
  localparam int CAUSE_TICK    = 5;
  localparam int CAUSE_EXTINT  = 8;
  localparam int CAUSE_SYSCALL = 12;
  localparam int CAUSE_FPU     = 13;

  typedef enum logic {
    ENTRY_IDLE = 1'b0,
    ENTRY_BUSY = 1'b1
  } entry_state_e;

endpackage

// File: rtl/exc_pc_select.sv
module exc_pc_select
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  parameter int INSN_BYTES = 4
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic               in_slot,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [XLEN-1:0]    nxt_pc,
  input  logic [XLEN-1:0]    br_pc,
  output logic               resume_after,
  output logic [XLEN-1:0]    save_pc
);

  function automatic logic is_resume_cls(input logic [CAUSE_W-1:0] c);
    return (c == CAUSE_W'(CAUSE_TICK))    || (c == CAUSE_W'(CAUSE_EXTINT)) ||
           (c == CAUSE_W'(CAUSE_SYSCALL)) || (c == CAUSE_W'(CAUSE_FPU));
  endfunction

  function automatic logic [XLEN-1:0] pick_pc(
    input logic            slot,
    input logic            resume,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] npc,
    input logic [XLEN-1:0] bpc
  );
    logic [XLEN-1:0] r;
    unique case ({slot, resume})
      2'b00:   r = pc;
      2'b01:   r = npc;
      2'b10:   r = pc - XLEN'(INSN_BYTES);
      default: r = bpc;
    endcase
    return r;
  endfunction

  always_comb begin
    resume_after = is_resume_cls(cause);
    save_pc      = pick_pc(in_slot, resume_after, cur_pc, nxt_pc, br_pc);
  end

endmodule

// File: rtl/exc_status_update.sv
module exc_status_update
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] sr_in,
  input  logic            in_slot,
  output logic [XLEN-1:0] sr_new
);

  localparam logic [XLEN-1:0] CLR_MASK =
    (XLEN'(1) << SRB_TICKE) | (XLEN'(1) << SRB_INTE) |
    (XLEN'(1) << SRB_DMMUE) | (XLEN'(1) << SRB_IMMUE);
  localparam logic [XLEN-1:0] SET_MASK = XLEN'(1) << SRB_SUPV;
  localparam logic [XLEN-1:0] DSX_MASK = XLEN'(1) << SRB_DSEXC;

  function automatic logic [XLEN-1:0] enter_status(
    input logic [XLEN-1:0] s,
    input logic            slot
  );
    logic [XLEN-1:0] r;
    r = (s & ~CLR_MASK) | SET_MASK;
    if (slot) r = r | DSX_MASK;
    return r;
  endfunction

  always_comb sr_new = enter_status(sr_in, in_slot);

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 5,
  parameter int EXC_COUNT = 15,
  parameter int VEC_SHIFT = 8
) (
  input  logic [CAUSE_W-1:0] cause,
  output logic               cause_ok,
  output logic [XLEN-1:0]    vec_pc
);

  localparam logic [CAUSE_W:0] LIMIT = (CAUSE_W+1)'(EXC_COUNT);

  function automatic logic in_range(input logic [CAUSE_W-1:0] c);
    return (c != '0) && ({1'b0, c} < LIMIT);
  endfunction

  function automatic logic [XLEN-1:0] vector_of(input logic [CAUSE_W-1:0] c);
    return XLEN'(c) << VEC_SHIFT;
  endfunction

  always_comb begin
    cause_ok = in_range(cause);
    vec_pc   = vector_of(cause);
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 5,
  parameter int EXC_COUNT = 15,
  parameter int VEC_SHIFT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [XLEN-1:0]    next_pc,
  input  logic [XLEN-1:0]    branch_pc,
  input  logic               in_dslot,
  input  logic [XLEN-1:0]    cur_sr,
  output logic [XLEN-1:0]    epcr_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    sr_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               done_o,
  output logic               tlb_flush_o,
  output logic               abort_o,
  output logic               immu_bypass_o,
  output logic               dmmu_bypass_o
);

  entry_state_e    state_q;
  logic            accept;
  logic            resume_after;
  logic            cause_ok;
  logic [XLEN-1:0] save_pc;
  logic [XLEN-1:0] sr_next;
  logic [XLEN-1:0] vec_pc;

  assign accept = req_valid && (state_q == ENTRY_IDLE);

  exc_pc_select #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_pcsel (
    .cause        (req_cause),
    .in_slot      (in_dslot),
    .cur_pc       (cur_pc),
    .nxt_pc       (next_pc),
    .br_pc        (branch_pc),
    .resume_after (resume_after),
    .save_pc      (save_pc)
  );

  exc_status_update #(.XLEN(XLEN)) u_srupd (
    .sr_in   (cur_sr),
    .in_slot (in_dslot),
    .sr_new  (sr_next)
  );

  exc_vector_gen #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .EXC_COUNT(EXC_COUNT), .VEC_SHIFT(VEC_SHIFT)
  ) u_vec (
    .cause    (req_cause),
    .cause_ok (cause_ok),
    .vec_pc   (vec_pc)
  );

  // One busy cycle after each accept; back to idle after it
  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ENTRY_IDLE;
    else        state_q <= accept ? ENTRY_BUSY : ENTRY_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      tlb_flush_o <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      done_o      <= accept;
      tlb_flush_o <= accept;
      abort_o     <= accept && !cause_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epcr_o        <= '0;
      esr_o         <= '0;
      sr_o          <= '0;
      pc_o          <= '0;
      immu_bypass_o <= 1'b0;
      dmmu_bypass_o <= 1'b0;
    end else if (accept) begin
      epcr_o        <= save_pc;
      esr_o         <= cur_sr;
      sr_o          <= sr_next;
      immu_bypass_o <= 1'b1;
      dmmu_bypass_o <= 1'b1;
      if (cause_ok) pc_o <= vec_pc;
    end
  end

  // Assertions
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done_o);
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_busy_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && req_valid) |=> ($stable(epcr_o) && $stable(sr_o) && !done_o));
  assert_esr_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (esr_o == $past(cur_sr)));
  assert_supervisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sr_o[SRB_SUPV] && !sr_o[SRB_INTE] && !sr_o[SRB_TICKE] &&
                !sr_o[SRB_DMMUE] && !sr_o[SRB_IMMUE]));
  assert_dsx_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_dslot) |=> sr_o[SRB_DSEXC]);
  assert_abort_holds_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cause_ok) |=> (abort_o && $stable(pc_o)));
  assert_flush_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tlb_flush_o && immu_bypass_o && dmmu_bypass_o));
  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !tlb_flush_o);
  assert_resume_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_dslot && resume_after) |=> (epcr_o == $past(branch_pc)));

endmodule

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [4:0]  req_cause;
  logic [31:0] cur_pc, next_pc, branch_pc, cur_sr;
  logic        in_dslot;
  logic [31:0] epcr_o, esr_o, sr_o, pc_o;
  logic        done_o, tlb_flush_o, abort_o, immu_bypass_o, dmmu_bypass_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_pc = 32'h0;

  always #10 clk = ~clk;

  exc_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
    .cur_pc(cur_pc), .next_pc(next_pc), .branch_pc(branch_pc),
    .in_dslot(in_dslot), .cur_sr(cur_sr),
    .epcr_o(epcr_o), .esr_o(esr_o), .sr_o(sr_o), .pc_o(pc_o),
    .done_o(done_o), .tlb_flush_o(tlb_flush_o), .abort_o(abort_o),
    .immu_bypass_o(immu_bypass_o), .dmmu_bypass_o(dmmu_bypass_o)
  );

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit later_class(input logic [4:0] c);
    case (c)
      5'd5, 5'd8, 5'd12, 5'd13: return 1'b1;
      default:                  return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] want_epc(input logic [4:0] c, input bit slot,
      input logic [31:0] pc, input logic [31:0] npc, input logic [31:0] bpc);
    if (slot) return later_class(c) ? bpc : pc + 32'hFFFF_FFFC;
    return later_class(c) ? npc : pc;
  endfunction

  function automatic logic [31:0] want_sr(input logic [31:0] s, input bit slot);
    logic [31:0] r;
    r = s & 32'hFFFF_FF99;
    r[0] = 1'b1;
    if (slot) r[13] = 1'b1;
    return r;
  endfunction

  function automatic bit want_valid(input logic [4:0] c);
    return (c >= 5'd1) && (c <= 5'd14);
  endfunction

  task automatic drive(input logic [4:0] c, input bit slot, input logic [31:0] pc,
                       input logic [31:0] npc, input logic [31:0] bpc,
                       input logic [31:0] s);
    req_valid = 1'b1; req_cause = c; in_dslot = slot;
    cur_pc = pc; next_pc = npc; branch_pc = bpc; cur_sr = s;
  endtask

  // Request at a negedge, accept at the next posedge, check at the negedge after
  task automatic entry(input logic [4:0] c, input bit slot, input logic [31:0] pc,
                       input logic [31:0] npc, input logic [31:0] bpc,
                       input logic [31:0] s);
    logic [31:0] e_epc;
    logic [31:0] e_sr;
    bit ok;
    e_epc = want_epc(c, slot, pc, npc, bpc);
    e_sr  = want_sr(s, slot);
    ok    = want_valid(c);
    if (ok) model_pc = {19'd0, c, 8'd0};
    drive(c, slot, pc, npc, bpc, s);
    @(negedge clk);
    req_valid = 1'b0;
    if (!slot && later_class(c))     chk(epcr_o == e_epc, "R2 epc", epcr_o, e_epc);
    else if (!slot)                  chk(epcr_o == e_epc, "R3 epc", epcr_o, e_epc);
    else if (later_class(c))         chk(epcr_o == e_epc, "R4 epc", epcr_o, e_epc);
    else                             chk(epcr_o == e_epc, "R5 epc", epcr_o, e_epc);
    chk(esr_o == s, "R6 esr", esr_o, s);
    chk(sr_o == e_sr, "R7 sr", sr_o, e_sr);
    if (ok) chk(pc_o == model_pc, "R8 vector", pc_o, model_pc);
    else    chk(pc_o == model_pc, "R9 pc held", pc_o, model_pc);
    chk(abort_o == !ok, "R9 abort", {31'd0, abort_o}, {31'd0, !ok});
    chk(done_o == 1'b1, "R1 done", {31'd0, done_o}, 32'd1);
    chk(tlb_flush_o && immu_bypass_o && dmmu_bypass_o, "R10 flush/bypass",
        {29'd0, tlb_flush_o, immu_bypass_o, dmmu_bypass_o}, 32'd7);
    @(negedge clk);
    chk(!done_o && !tlb_flush_o && !abort_o, "R1 R10 single pulse",
        {29'd0, done_o, tlb_flush_o, abort_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_cause = '0; in_dslot = 1'b0;
    cur_pc = '0; next_pc = '0; branch_pc = '0; cur_sr = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk({epcr_o, esr_o, sr_o, pc_o} == '0, "R11 reset regs", pc_o, 32'd0);
    chk({done_o, tlb_flush_o, abort_o, immu_bypass_o, dmmu_bypass_o} == '0,
        "R11 reset flags", {27'd0, done_o, tlb_flush_o, abort_o, immu_bypass_o,
        dmmu_bypass_o}, 32'd0);

    // Directed corners
    entry(5'd5,  1'b0, 32'h0000_1000, 32'h0000_1004, 32'h0000_8000, 32'h0000_0066);
    entry(5'd7,  1'b0, 32'h0000_2000, 32'h0000_2004, 32'h0000_9000, 32'h0000_0000);
    entry(5'd8,  1'b1, 32'h0000_3004, 32'h0000_3008, 32'h0000_A000, 32'hFFFF_FFFF);
    entry(5'd6,  1'b1, 32'h0000_4004, 32'h0000_4008, 32'h0000_B000, 32'h1234_5678);
    entry(5'd12, 1'b0, 32'h0000_0000, 32'h0000_0004, 32'h0000_C000, 32'h0000_2000);
    entry(5'd13, 1'b1, 32'h0000_0000, 32'h0000_0004, 32'hDEAD_BEE0, 32'h0000_0000);
    entry(5'd2,  1'b1, 32'h0000_0000, 32'h0000_0004, 32'h0000_1111, 32'h0000_0000);
    entry(5'd14, 1'b0, 32'h0000_5000, 32'h0000_5004, 32'h0, 32'h0000_0040);
    entry(5'd1,  1'b0, 32'h0000_6000, 32'h0000_6004, 32'h0, 32'h0000_0020);
    entry(5'd0,  1'b0, 32'h0000_7000, 32'h0000_7004, 32'h0, 32'h0000_0004);
    entry(5'd15, 1'b1, 32'h0000_7100, 32'h0000_7104, 32'h0, 32'h0000_0002);
    entry(5'd31, 1'b0, 32'h0000_7200, 32'h0000_7204, 32'h0, 32'h8000_0000);

    // R1: request held through the busy cycle is ignored
    drive(5'd3, 1'b0, 32'h0000_AA00, 32'h0000_AA04, 32'h0, 32'h0000_0100);
    @(negedge clk);
    model_pc = 32'h0000_0300;
    drive(5'd9, 1'b1, 32'h0000_BB00, 32'h0000_BB04, 32'h0000_CC00, 32'h0000_FFFF);
    chk(done_o, "R1 first taken", {31'd0, done_o}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(epcr_o == 32'h0000_AA00, "R1 busy ignored epc", epcr_o, 32'h0000_AA00);
    chk(sr_o == want_sr(32'h0000_0100, 1'b0), "R1 busy ignored sr", sr_o,
        want_sr(32'h0000_0100, 1'b0));
    chk(pc_o == model_pc, "R1 busy ignored pc", pc_o, model_pc);
    chk(esr_o == 32'h0000_0100, "R1 busy ignored esr", esr_o, 32'h0000_0100);
    chk(!done_o && !tlb_flush_o, "R1 busy no pulse",
        {30'd0, done_o, tlb_flush_o}, 32'd0);

    // Seeded random requests
    for (int i = 0; i < 80; i++) begin
      logic [31:0] rpc;
      rpc = $urandom() & 32'hFFFF_FFFC;
      entry(5'($urandom() % 32), 1'($urandom() % 2), rpc, rpc + 32'd4,
            $urandom() & 32'hFFFF_FFFC, $urandom());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule